// File: doc/BRIEF.md
# Parallel Handshake Port Adapter

This block sits between a serial byte-link engine and two independent byte-wide parallel ports, each with its own two-wire valid/acknowledge handshake. On the input port, a peripheral offers a byte by raising a valid line. The adapter captures the byte and asks the link engine to transmit it. It confirms the transfer to the peripheral only once the byte has left and the far end has answered with a link acknowledge.

On the output port, each data byte that the link engine reports is placed on the parallel outputs and then flagged valid. The link acknowledge that lets the far end send again is requested from the engine only after the peripheral has confirmed that it read the byte. Because of this, at most one received byte is ever outstanding. The serial framing, bit timing and line encoding all belong to the link engine. This block sees only per-byte pulses and levels.

The two handshake inputs coming from the peripheral are asynchronous to the block clock, so each passes through a flip-flop synchroniser before use. The external reset is asserted asynchronously and released synchronously inside the block.

Top module: `byte_port_bridge`

## Requirements
- R1: While reset is applied, and after it is released with no stimulus, `pin_ack`, `pout_valid`, `lnk_tx_req` and `lnk_ack_send` are all 0.
- R2: Once a high `pin_valid` has passed the synchroniser, `lnk_tx_req` rises. `lnk_tx_data` then carries the byte that was on `pin_data`, and both stay unchanged until a `lnk_tx_done` pulse.
- R3: `pin_ack` rises only when both a `lnk_tx_done` pulse and a `lnk_ack_rx` pulse have arrived for the current byte, in either order. It rises on the clock edge that samples the later of the two.
- R4: `pin_ack` stays high, and no new `lnk_tx_req` is raised, for as long as `pin_valid` stays high. After `pin_valid` falls, `pin_ack` falls once the low level has passed the synchroniser.
- R5: A `lnk_rx_valid` pulse sampled while the output port is idle loads `lnk_rx_data` into `pout_data` at that clock edge. `pout_valid` rises one cycle later.
- R6: When a high `pout_ack` has passed the synchroniser, `lnk_ack_send` gives exactly one one-cycle pulse, and `pout_valid` falls on that same edge. No `lnk_ack_send` pulse occurs at any other time.
- R7: `pout_data` keeps its value after `pout_valid` falls, until the next accepted received byte replaces it.
- R8: `pout_data` is loaded only by `lnk_rx_valid` pulses. A `lnk_ack_rx` pulse never changes it, and neither does a `lnk_rx_valid` pulse that arrives while a byte is still pending on the output port. Neither kind of pulse causes a `lnk_ack_send`.
- R9: `pin_valid` and `pout_ack` pass through SYNC_STAGES flip-flops (default 2) before the control logic sees them. The first output response comes on the edge after the last stage captures the new level, which is the third clock edge at the default setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_data | input | 8 | Byte offered by the input-side peripheral |
| pin_valid | input | 1 | Input byte valid (asynchronous) |
| pin_ack | output | 1 | Input byte delivered and acknowledged by the far end |
| pout_data | output | 8 | Last received byte, held until replaced |
| pout_valid | output | 1 | Output byte waiting to be read |
| pout_ack | input | 1 | Peripheral has read the output byte (asynchronous) |
| lnk_tx_req | output | 1 | Request to the link engine to send `lnk_tx_data` |
| lnk_tx_data | output | 8 | Byte to transmit |
| lnk_tx_done | input | 1 | One-cycle pulse: data packet fully sent |
| lnk_ack_rx | input | 1 | One-cycle pulse: acknowledge packet received |
| lnk_rx_valid | input | 1 | One-cycle pulse: data byte received |
| lnk_rx_data | input | 8 | Received byte, valid with `lnk_rx_valid` |
| lnk_ack_send | output | 1 | One-cycle pulse: send an acknowledge packet |

## Verification
The bench delivers the far-end acknowledge both before and after the transmit-done pulse. A design that waits for a fixed order would then hang, and one that reacts to either event alone would raise `pin_ack` early. It also holds `pin_valid` high well past the acknowledge, which catches a design that drops `pin_ack` early or starts a second send. On the output side, the bench fires stray received bytes and acknowledge packets while a byte is pending and while the port is idle. A design that loads on any link event, or that frees the far end too soon, would corrupt `pout_data` or emit an extra `lnk_ack_send`. Exact-cycle checks on the synchroniser latency and on the ordering of data before valid catch a missing stage or a valid flag raised together with its data.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
  typedef enum logic [1:0] {
    IN_IDLE,
    IN_SEND,
    IN_WAIT,
    IN_DONE
  } in_state_e;

  typedef enum logic [2:0] {
    OUT_IDLE,
    OUT_LOAD,
    OUT_SHOW,
    OUT_ACK,
    OUT_REL
  } out_state_e;
endpackage

// File: rtl/bpb_sync.sv
module bpb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/bpb_in_port.sv
module bpb_in_port
  import bpb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              vld_s,
  output logic              pin_ack,
  output logic              tx_req,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_done,
  input  logic              ack_rx
);
  in_state_e         state_q, state_d;
  logic              ack_seen_q, ack_seen_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  always_comb begin
    state_d    = state_q;
    ack_seen_d = 1'b0;
    data_en    = 1'b0;
    case (state_q)
      IN_IDLE: begin
        if (vld_s) begin
          state_d = IN_SEND;
          data_en = 1'b1;
        end
      end
      IN_SEND: begin
        ack_seen_d = ack_seen_q | ack_rx;
        if (tx_done) begin
          state_d    = (ack_seen_q || ack_rx) ? IN_DONE : IN_WAIT;
          ack_seen_d = 1'b0;
        end
      end
      IN_WAIT: begin
        if (ack_rx) state_d = IN_DONE;
      end
      IN_DONE: begin
        if (!vld_s) state_d = IN_IDLE;
      end
      default: state_d = IN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= IN_IDLE;
      ack_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ack_seen_q <= ack_seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= pin_data;
  end

  assign tx_req  = (state_q == IN_SEND);
  assign tx_data = data_q;
  assign pin_ack = (state_q == IN_DONE);
endmodule

// File: rtl/bpb_out_port.sv
module bpb_out_port
  import bpb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              ack_s,
  output logic [DATA_W-1:0] pout_data,
  output logic              pout_valid,
  output logic              ack_send
);
  out_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic              load_en;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    case (state_q)
      OUT_IDLE: begin
        if (rx_valid) begin
          state_d = OUT_LOAD;
          load_en = 1'b1;
        end
      end
      OUT_LOAD: state_d = OUT_SHOW;
      OUT_SHOW: begin
        if (ack_s) state_d = OUT_ACK;
      end
      OUT_ACK:  state_d = OUT_REL;
      OUT_REL: begin
        if (!ack_s) state_d = OUT_IDLE;
      end
      default:  state_d = OUT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= OUT_IDLE;
    else        state_q <= state_d;
  end

  // Per-bit load: a bit rewritten with its own value does not toggle.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q[b] <= 1'b0;
      else if (load_en) data_q[b] <= rx_data[b];
    end
  end

  assign pout_data  = data_q;
  assign pout_valid = (state_q == OUT_SHOW);
  assign ack_send   = (state_q == OUT_ACK);
endmodule

// File: rtl/byte_port_bridge.sv
module byte_port_bridge #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_valid,
  output logic              pin_ack,
  output logic [DATA_W-1:0] pout_data,
  output logic              pout_valid,
  input  logic              pout_ack,
  output logic              lnk_tx_req,
  output logic [DATA_W-1:0] lnk_tx_data,
  input  logic              lnk_tx_done,
  input  logic              lnk_ack_rx,
  input  logic              lnk_rx_valid,
  input  logic [DATA_W-1:0] lnk_rx_data,
  output logic              lnk_ack_send
);
  localparam int NUM_ASYNC = 2;

  logic [1:0]           rst_pipe_q;
  logic                 rst_n_sync;
  logic [NUM_ASYNC-1:0] hs_raw, hs_sync;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  assign hs_raw = {pout_ack, pin_valid};

  bpb_sync #(
    .WIDTH  (NUM_ASYNC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .d_async (hs_raw),
    .q_sync  (hs_sync)
  );

  bpb_in_port #(
    .DATA_W (DATA_W)
  ) u_in (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .pin_data (pin_data),
    .vld_s    (hs_sync[0]),
    .pin_ack  (pin_ack),
    .tx_req   (lnk_tx_req),
    .tx_data  (lnk_tx_data),
    .tx_done  (lnk_tx_done),
    .ack_rx   (lnk_ack_rx)
  );

  bpb_out_port #(
    .DATA_W (DATA_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .rx_valid   (lnk_rx_valid),
    .rx_data    (lnk_rx_data),
    .ack_s      (hs_sync[1]),
    .pout_data  (pout_data),
    .pout_valid (pout_valid),
    .ack_send   (lnk_ack_send)
  );
endmodule

// File: rtl/bpb_checker.sv
module bpb_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pin_valid,
  input logic              pin_ack,
  input logic [DATA_W-1:0] pout_data,
  input logic              pout_valid,
  input logic              lnk_tx_req,
  input logic [DATA_W-1:0] lnk_tx_data,
  input logic              lnk_tx_done,
  input logic              lnk_ack_rx,
  input logic              lnk_rx_valid,
  input logic              lnk_ack_send
);
  logic seen_done_q, seen_ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_done_q <= 1'b0;
      seen_ack_q  <= 1'b0;
    end else if (pin_ack) begin
      seen_done_q <= 1'b0;
      seen_ack_q  <= 1'b0;
    end else begin
      seen_done_q <= seen_done_q | lnk_tx_done;
      seen_ack_q  <= seen_ack_q  | lnk_ack_rx;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!pin_ack && !pout_valid && !lnk_tx_req && !lnk_ack_send)
        else $error("R1 outputs active during reset");
    end
  end

  p_req_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_tx_req && !lnk_tx_done |=> lnk_tx_req && $stable(lnk_tx_data));

  p_ack_after_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_ack) |-> $past(seen_done_q || lnk_tx_done) && $past(seen_ack_q || lnk_ack_rx));

  p_ack_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ack && pin_valid |=> pin_ack);

  p_no_req_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ack |-> !lnk_tx_req);

  p_data_before_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pout_valid) |-> $stable(pout_data));

  p_send_drops_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_ack_send |-> !pout_valid && $past(pout_valid));

  p_send_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_ack_send |=> !lnk_ack_send);

  p_data_only_on_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pout_data) |-> $past(lnk_rx_valid) && !$past(pout_valid));
endmodule

bind byte_port_bridge bpb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .pin_valid    (pin_valid),
  .pin_ack      (pin_ack),
  .pout_data    (pout_data),
  .pout_valid   (pout_valid),
  .lnk_tx_req   (lnk_tx_req),
  .lnk_tx_data  (lnk_tx_data),
  .lnk_tx_done  (lnk_tx_done),
  .lnk_ack_rx   (lnk_ack_rx),
  .lnk_rx_valid (lnk_rx_valid),
  .lnk_ack_send (lnk_ack_send)
);

// File: tb/byte_port_bridge_tb.sv
module byte_port_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic [7:0] pin_data;
  logic       pin_valid;
  logic       pin_ack;
  logic [7:0] pout_data;
  logic       pout_valid;
  logic       pout_ack;
  logic       lnk_tx_req;
  logic [7:0] lnk_tx_data;
  logic       lnk_tx_done;
  logic       lnk_ack_rx;
  logic       lnk_rx_valid;
  logic [7:0] lnk_rx_data;
  logic       lnk_ack_send;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  byte_port_bridge u_dut (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .pin_data     (pin_data),
    .pin_valid    (pin_valid),
    .pin_ack      (pin_ack),
    .pout_data    (pout_data),
    .pout_valid   (pout_valid),
    .pout_ack     (pout_ack),
    .lnk_tx_req   (lnk_tx_req),
    .lnk_tx_data  (lnk_tx_data),
    .lnk_tx_done  (lnk_tx_done),
    .lnk_ack_rx   (lnk_ack_rx),
    .lnk_rx_valid (lnk_rx_valid),
    .lnk_rx_data  (lnk_rx_data),
    .lnk_ack_send (lnk_ack_send)
  );

  // {ack_first, input-port byte, output-port byte}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h3C},
    {1'b1, 8'h00, 8'hFF},
    {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h5A, 8'h5A},
    {1'b0, 8'h81, 8'h7E},
    {1'b1, 8'h7E, 8'h81}
  };

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_done();
    lnk_tx_done = 1'b1; tick(); lnk_tx_done = 1'b0;
  endtask

  task automatic pulse_ack();
    lnk_ack_rx = 1'b1; tick(); lnk_ack_rx = 1'b0;
  endtask

  task automatic pulse_rx(input logic [7:0] d);
    lnk_rx_data = d; lnk_rx_valid = 1'b1; tick(); lnk_rx_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int sends;
    rst_ni = 1'b0; pin_data = '0; pin_valid = 1'b0; pout_ack = 1'b0;
    lnk_tx_done = 1'b0; lnk_ack_rx = 1'b0; lnk_rx_valid = 1'b0; lnk_rx_data = '0;
    tick(3);
    chk({pin_ack, pout_valid, lnk_tx_req, lnk_ack_send} == 4'b0, "R1 in reset",
        {pin_ack, pout_valid, lnk_tx_req, lnk_ack_send}, 0);
    rst_ni = 1'b1;
    tick(4);
    chk({pin_ack, pout_valid, lnk_tx_req, lnk_ack_send} == 4'b0, "R1 after release",
        {pin_ack, pout_valid, lnk_tx_req, lnk_ack_send}, 0);

    // R8: acknowledge packet on an idle output port loads nothing
    pulse_rx(8'h11); tick();
    pout_ack = 1'b1; tick(4); pout_ack = 1'b0; tick(4);
    lnk_rx_data = 8'hEE; lnk_ack_rx = 1'b1; tick(); lnk_ack_rx = 1'b0; tick(2);
    chk(pout_data == 8'h11, "R8 ack packet no load", pout_data, 8'h11);
    chk(lnk_ack_send == 1'b0, "R8 ack packet no send", lnk_ack_send, 0);

    foreach (VEC[i]) begin
      logic       ack_first = VEC[i][16];
      logic [7:0] ib = VEC[i][15:8];
      logic [7:0] ob = VEC[i][7:0];

      // input port
      pin_data = ib; pin_valid = 1'b1;
      tick(2);
      chk(lnk_tx_req == 1'b0, "R9 valid still in synchroniser", lnk_tx_req, 0);
      tick();
      chk(lnk_tx_req == 1'b1, "R2 request raised", lnk_tx_req, 1);
      chk(lnk_tx_data == ib, "R2 transmit byte", lnk_tx_data, ib);
      if (ack_first) begin
        pulse_ack();
        chk(pin_ack == 1'b0, "R3 ack alone", pin_ack, 0);
        tick(3);
        chk(lnk_tx_req == 1'b1 && lnk_tx_data == ib, "R2 request held", lnk_tx_req, 1);
        pulse_done();
        chk(pin_ack == 1'b1, "R3 done after ack", pin_ack, 1);
      end else begin
        pulse_done();
        chk(pin_ack == 1'b0 && lnk_tx_req == 1'b0, "R3 done alone",
            {pin_ack, lnk_tx_req}, 0);
        tick(3);
        chk(pin_ack == 1'b0, "R3 waiting for far ack", pin_ack, 0);
        pulse_ack();
        chk(pin_ack == 1'b1, "R3 ack after done", pin_ack, 1);
      end
      tick(4);
      chk(pin_ack == 1'b1 && lnk_tx_req == 1'b0, "R4 ack held while valid",
          {pin_ack, lnk_tx_req}, 2'b10);
      pin_valid = 1'b0;
      tick(2);
      chk(pin_ack == 1'b1, "R4 ack during synchroniser lag", pin_ack, 1);
      tick();
      chk(pin_ack == 1'b0, "R4 ack released", pin_ack, 0);

      // output port
      pulse_rx(ob);
      chk(pout_data == ob, "R5 data loaded", pout_data, ob);
      chk(pout_valid == 1'b0, "R5 valid not yet", pout_valid, 0);
      tick();
      chk(pout_valid == 1'b1, "R5 valid raised", pout_valid, 1);
      pulse_rx(~ob);
      lnk_ack_rx = 1'b1; tick(); lnk_ack_rx = 1'b0;
      chk(pout_data == ob, "R8 pending byte kept", pout_data, ob);
      chk(lnk_ack_send == 1'b0, "R8 no early link ack", lnk_ack_send, 0);
      pout_ack = 1'b1;
      tick(2);
      chk(pout_valid == 1'b1 && lnk_ack_send == 1'b0, "R9 read ack in synchroniser",
          {pout_valid, lnk_ack_send}, 2'b10);
      sends = 0;
      for (int k = 0; k < 6; k++) begin
        tick();
        if (lnk_ack_send) begin
          sends++;
          chk(pout_valid == 1'b0, "R6 valid low with link ack", pout_valid, 0);
          chk(k == 0, "R6 link ack cycle", k, 0);
        end
      end
      chk(sends == 1, "R6 single link ack", sends, 1);
      pout_ack = 1'b0;
      tick(4);
      chk(pout_data == ob && pout_valid == 1'b0, "R7 data held after handshake",
          pout_data, ob);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule